// File: doc/BRIEF.md
# SAR frame read sequencer

This block is the host-side timing master for an external successive-approximation converter. While enabled it raises a one-cycle conversion strobe at a fixed frame period. It then reads the result of the previous conversion over a three-wire serial link: an active-low select, a serial clock and one data input. Frame length, conversion time, quiet interval and read start are counted in system-clock ticks. The serial clock half-period is a run-time divider value.

Two read placements are available. In the late placement the select falls once the conversion time has elapsed, so the transfer must fit between the end of conversion and the quiet interval. In the early placement the select falls in the same cycle as the strobe, so the transfer overlaps the conversion and a much slower serial clock fits the frame. In both placements the serial clock and the select are frozen during the last ticks of the frame, just before the next sample instant. A combinational check flags any setting whose transfer would reach into that quiet interval, and no frame starts while the flag is high.

Recovered words leave on a valid/ready output. Frames never stall for back-pressure. A word that has not been accepted is replaced by the next one, so a slow consumer sees the latest sample. With ready tied high, valid is a single-cycle pulse per word.

Top module: `sar_frame_seq`

## Requirements
- R1: During and right after reset, select is high, serial clock is low, the strobe is low and output valid is low.
- R2: While run_en is high and the configuration is legal, the strobe is high for exactly one cycle every CYCLE_TICKS cycles. When run_en falls, the frame in progress completes and no further strobe follows.
- R3: The first frame after the block leaves idle performs no read (select stays high). Every later frame performs exactly one read with exactly WORD_W rising serial clock edges.
- R4: With wide_mode low, select falls CONV_TICKS cycles after the strobe rises. With wide_mode high, select falls in the same cycle in which the strobe rises.
- R5: The serial clock idles low. Its first rise comes one cycle after select falls. Each high phase lasts sclk_div cycles and each low phase between bits lasts sclk_div cycles. Select rises one cycle after the last falling edge.
- R6: Neither the serial clock nor select changes during the last QUIET_TICKS cycles of a frame.
- R7: Data is taken MSB first on each rising serial clock edge. The word read in a frame is the result of the conversion started by the previous frame's strobe.
- R8: cfg_err is high exactly when sclk_div < 2 or when start + 2 + (2*WORD_W-1)*sclk_div > CYCLE_TICKS - QUIET_TICKS - 1. Here start is 0 with wide_mode high and CONV_TICKS otherwise. While cfg_err is high no frame starts.
- R9: res_valid stays high with res_data unchanged until res_ready is seen high. A newer word replaces an unaccepted one. res_valid falls in the cycle after acceptance unless a new word arrives in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all durations count its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Frames start and continue only while high |
| wide_mode | input | 1 | 1: read starts at the strobe; 0: read starts after conversion; sampled at each frame start |
| sclk_div | input | DIV_W | Serial clock half-period in system cycles; sampled when a read begins |
| cfg_err | output | 1 | Current settings cannot fit the word before the quiet interval |
| cnvst | output | 1 | Conversion-start strobe to the converter |
| cs_n | output | 1 | Active-low select to the converter |
| sclk | output | 1 | Serial clock to the converter |
| sdo | input | 1 | Serial data from the converter |
| res_valid | output | 1 | A recovered word is on res_data |
| res_ready | input | 1 | Consumer accepts the word |
| res_data | output | WORD_W | Recovered conversion word |

## Verification
A wrong frame counter or a wrong first-frame flag shows up at the pins within one frame: the strobe spacing drifts, the select falls at the wrong distance from the strobe, or a read appears in the first frame. A wrong phase or bit counter in the serial engine shows up within one read as wrong pulse widths, a wrong count of rising edges, or a select edge inside the quiet interval. It also garbles the recovered word, which is compared against a known converter sequence at the handshake. A faulty output holding register is caught while ready is held low, because valid would drop or a stale word would remain.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_LEAD,
    RD_SHIFT,
    RD_TAIL
  } rd_state_e;

  // Ticks from select falling to select rising for one read.
  function automatic logic [31:0] read_span(input int word_w, input logic [31:0] half);
    read_span = 32'd2 + 32'(2 * word_w - 1) * half;
  endfunction

endpackage

// File: rtl/sar_frame_timer.sv
module sar_frame_timer #(
  parameter int CYCLE_TICKS = 160,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             cfg_ok,
  output logic             start,
  output logic             active,
  output logic             first,
  output logic             cnvst,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(CYCLE_TICKS - 1);

  assign start = run_en && cfg_ok && (!active || cnt == LAST_TICK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      first  <= 1'b0;
      cnvst  <= 1'b0;
      cnt    <= '0;
    end else begin
      cnvst <= start;
      if (start) begin
        active <= 1'b1;
        first  <= !active;
        cnt    <= '0;
      end else if (active) begin
        if (cnt == LAST_TICK) begin
          active <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2: the strobe never lasts more than one cycle
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cnvst |=> !cnvst);

endmodule

// File: rtl/sar_read_gen.sv
module sar_read_gen
  import sar_seq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DIV_W-1:0] div,
  output logic             cs_n,
  output logic             sclk,
  output logic             samp,
  output logic             last_bit
);

  localparam int BIT_W = $clog2(WORD_W);
  localparam int PH_W  = DIV_W + 1;

  rd_state_e        st;
  logic [DIV_W-1:0] div_l;
  logic [PH_W-1:0]  ph;
  logic [PH_W-1:0]  half_end;
  logic [PH_W-1:0]  full_end;
  logic [BIT_W-1:0] bit_i;

  assign half_end = PH_W'(div_l) - PH_W'(1);
  assign full_end = {div_l, 1'b0} - PH_W'(1);
  assign last_bit = (bit_i == BIT_W'(WORD_W - 1));
  // first cycle of each high phase: capture at the following edge
  assign samp     = (st == RD_SHIFT) && (ph == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= RD_IDLE;
      cs_n  <= 1'b1;
      sclk  <= 1'b0;
      ph    <= '0;
      bit_i <= '0;
      div_l <= '0;
    end else begin
      case (st)
        RD_IDLE: begin
          if (go) begin
            cs_n  <= 1'b0;
            div_l <= div;
            st    <= RD_LEAD;
          end
        end
        RD_LEAD: begin
          sclk  <= 1'b1;
          ph    <= '0;
          bit_i <= '0;
          st    <= RD_SHIFT;
        end
        RD_SHIFT: begin
          if (ph == half_end) begin
            sclk <= 1'b0;
            if (last_bit) begin
              st <= RD_TAIL;
            end else begin
              ph <= ph + 1'b1;
            end
          end else if (ph == full_end) begin
            sclk  <= 1'b1;
            ph    <= '0;
            bit_i <= bit_i + 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        RD_TAIL: begin
          cs_n <= 1'b1;
          st   <= RD_IDLE;
        end
        default: st <= RD_IDLE;
      endcase
    end
  end

  // R5: the serial clock only runs inside an active select
  a_r5_sclk_within_cs: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

endmodule

// File: rtl/sar_shift_in.sv
module sar_shift_in #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp,
  input  logic              last_bit,
  input  logic              sdo,
  output logic              done,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      word <= '0;
      done <= 1'b0;
    end else begin
      done <= samp && last_bit;
      if (samp) begin
        sh <= {sh[WORD_W-2:0], sdo};
        if (last_bit) begin
          word <= {sh[WORD_W-2:0], sdo};
        end
      end
    end
  end

endmodule

// File: rtl/sar_frame_seq.sv
module sar_frame_seq
  import sar_seq_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int CYCLE_TICKS = 160,
  parameter int CONV_TICKS  = 120,
  parameter int QUIET_TICKS = 10,
  parameter int DIV_W       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              wide_mode,
  input  logic [DIV_W-1:0]  sclk_div,
  output logic              cfg_err,
  output logic              cnvst,
  output logic              cs_n,
  output logic              sclk,
  input  logic              sdo,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [WORD_W-1:0] res_data
);

  localparam int CNT_W      = $clog2(CYCLE_TICKS);
  localparam int QUIET_FROM = CYCLE_TICKS - QUIET_TICKS;
  localparam int LAST_LEGAL = QUIET_FROM - 1;

  // ---------------- configuration check ----------------
  logic [31:0] rd_span;
  logic [31:0] rd_ofs;
  logic        cfg_ok;

  always_comb begin
    rd_span = read_span(WORD_W, 32'(sclk_div));
    rd_ofs  = wide_mode ? 32'd0 : 32'(CONV_TICKS);
    cfg_ok  = (sclk_div >= DIV_W'(2)) && ((rd_ofs + rd_span) <= 32'(LAST_LEGAL));
  end

  assign cfg_err = !cfg_ok;

  // ---------------- frame timing ----------------
  logic             start;
  logic             active;
  logic             first;
  logic [CNT_W-1:0] cnt;

  sar_frame_timer #(
    .CYCLE_TICKS(CYCLE_TICKS),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run_en(run_en),
    .cfg_ok(cfg_ok),
    .start (start),
    .active(active),
    .first (first),
    .cnvst (cnvst),
    .cnt   (cnt)
  );

  logic             mode_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_sel;
  logic             go_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      div_q  <= '0;
    end else if (start) begin
      mode_q <= wide_mode;
      div_q  <= sclk_div;
    end
  end

  assign div_sel = start ? sclk_div : div_q;
  // early read: launched together with a continuing frame's strobe
  // late read: launched so select falls CONV_TICKS after the strobe
  assign go_rd = (start && active && wide_mode) ||
                 (active && !first && !mode_q && cnt == CNT_W'(CONV_TICKS - 1));

  // ---------------- serial engine ----------------
  logic              samp;
  logic              last_bit;
  logic              sh_done;
  logic [WORD_W-1:0] sh_word;

  sar_read_gen #(
    .WORD_W(WORD_W),
    .DIV_W (DIV_W)
  ) u_read (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go_rd),
    .div     (div_sel),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .samp    (samp),
    .last_bit(last_bit)
  );

  sar_shift_in #(
    .WORD_W(WORD_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .samp    (samp),
    .last_bit(last_bit),
    .sdo     (sdo),
    .done    (sh_done),
    .word    (sh_word)
  );

  // ---------------- output holding register ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (sh_done) begin
      res_valid <= 1'b1;
      res_data  <= sh_word;
    end else if (res_valid && res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R6: bus frozen in the quiet tail of every frame
  a_r6_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt >= CNT_W'(QUIET_FROM)) |-> ($stable(sclk) && $stable(cs_n)));

  // R3: no bus activity in the first frame after leaving idle
  a_r3_first_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (active && first) |-> cs_n);

  // R9: an unaccepted word is held unchanged
  a_r9_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !sh_done) |=> (res_valid && $stable(res_data)));

endmodule

// File: tb/test_sar_frame_seq.sv
module conv_model #(
  parameter int W = 16
) (
  input  logic cnvst,
  input  logic sclk,
  output logic sdo,
  output int   n
);
  logic [W-1:0] conv_v;
  logic [W-1:0] sh;
  logic         pc;
  logic         ps;

  function automatic logic [31:0] seq_word(input int i);
    logic [31:0] v;
    v = 32'h9E37_79B9 * 32'(i + 1);
    v = v ^ (v >> 13);
    return v;
  endfunction

  initial begin
    n = 0; conv_v = '0; sh = '0; pc = 1'b0; ps = 1'b0;
  end

  always @(cnvst or sclk) begin
    if (cnvst && !pc) begin
      sh     = conv_v;
      conv_v = seq_word(n)[W-1:0];
      n      = n + 1;
    end
    if (!sclk && ps) sh = {sh[W-2:0], 1'b0};
    pc = cnvst;
    ps = sclk;
  end

  assign sdo = sh[W-1];
endmodule

module bus_mon #(
  parameter int CYCLE = 160,
  parameter int QUIET = 10
) (
  input logic       clk,
  input logic       cnvst,
  input logic       cs_n,
  input logic       sclk,
  input logic [5:0] div
);
  int cyc = 0, pos = 0, strobes = 0, period_bad = 0, quiet_viol = 0;
  int cs_falls = 0, cs_off = -1, rises = 0, last_rises = 0, pulse_bad = 0;
  int t_cs = 0, t_hi = 0, t_lo = 0;
  bit seen = 0;
  logic pcn = 1'b0, pcs = 1'b1, psc = 1'b0;

  always @(negedge clk) begin
    cyc++;
    pos++;
    if (cnvst && !pcn) begin
      if (seen && pos != CYCLE) period_bad++;
      pos = 0; seen = 1; strobes++;
    end
    if (seen && pos >= CYCLE - QUIET && (cs_n !== pcs || sclk !== psc)) quiet_viol++;
    if (!cs_n && pcs) begin cs_falls++; cs_off = pos; rises = 0; t_cs = cyc; end
    if (sclk && !psc) begin
      rises++;
      if (rises == 1 && cyc - t_cs != 1) pulse_bad++;
      t_hi = cyc;
    end
    if (!sclk && psc) begin
      if (cyc - t_hi != int'(div)) pulse_bad++;
      t_lo = cyc;
    end
    if (cs_n && !pcs) begin
      if (cyc - t_lo != 1) pulse_bad++;
      last_rises = rises;
    end
    pcn = cnvst; pcs = cs_n; psc = sclk;
  end
endmodule

module test_sar_frame_seq;
  localparam int AW = 16, AC = 160, AV = 120, AQ = 10;
  localparam int BW = 18, BC = 400, BV = 120, BQ = 20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic en_a, wide_a, ra, va, err_a, cnv_a, cs_a, sck_a, sdo_a;
  logic [5:0] div_a;
  logic [AW-1:0] da;
  logic en_b, wide_b, rb, vb, err_b, cnv_b, cs_b, sck_b, sdo_b;
  logic [5:0] div_b;
  logic [BW-1:0] db;
  int na_model, nb_model;

  sar_frame_seq i_sar_frame_seq (
    .clk(clk), .rst_n(rst_n), .run_en(en_a), .wide_mode(wide_a), .sclk_div(div_a),
    .cfg_err(err_a), .cnvst(cnv_a), .cs_n(cs_a), .sclk(sck_a), .sdo(sdo_a),
    .res_valid(va), .res_ready(ra), .res_data(da));

  sar_frame_seq #(.WORD_W(BW), .CYCLE_TICKS(BC), .CONV_TICKS(BV), .QUIET_TICKS(BQ)) i_sar_frame_seq_b (
    .clk(clk), .rst_n(rst_n), .run_en(en_b), .wide_mode(wide_b), .sclk_div(div_b),
    .cfg_err(err_b), .cnvst(cnv_b), .cs_n(cs_b), .sclk(sck_b), .sdo(sdo_b),
    .res_valid(vb), .res_ready(rb), .res_data(db));

  conv_model #(.W(AW)) m_a (.cnvst(cnv_a), .sclk(sck_a), .sdo(sdo_a), .n(na_model));
  conv_model #(.W(BW)) m_b (.cnvst(cnv_b), .sclk(sck_b), .sdo(sdo_b), .n(nb_model));
  bus_mon #(.CYCLE(AC), .QUIET(AQ)) mon_a (.clk(clk), .cnvst(cnv_a), .cs_n(cs_a), .sclk(sck_a), .div(div_a));
  bus_mon #(.CYCLE(BC), .QUIET(BQ)) mon_b (.clk(clk), .cnvst(cnv_b), .cs_n(cs_b), .sclk(sck_b), .div(div_b));

  logic [31:0] wa [64];
  logic [31:0] wb [64];
  int na = 0, nb = 0;
  always @(posedge clk) begin
    if (rst_n && va && ra) begin if (na < 64) wa[na] = 32'(da); na++; end
    if (rst_n && vb && rb) begin if (nb < 64) wb[nb] = 32'(db); nb++; end
  end

  int tests = 0, fails = 0;
  bit finished = 0;

  function automatic logic [31:0] expw(input int i, input int w);
    logic [31:0] v;
    v = 32'h9E37_79B9 * 32'(i + 1);
    v = v ^ (v >> 13);
    return v & ((32'h1 << w) - 32'h1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic t_reset();
    chk(cs_a == 1'b1 && cs_b == 1'b1, "R1", "select high", {cs_a, cs_b}, 3);
    chk(sck_a == 1'b0 && sck_b == 1'b0, "R1", "sclk low", {sck_a, sck_b}, 0);
    chk(cnv_a == 1'b0 && cnv_b == 1'b0, "R1", "strobe low", {cnv_a, cnv_b}, 0);
    chk(va == 1'b0 && vb == 1'b0, "R1", "valid low", {va, vb}, 0);
  endtask

  task automatic t_config();
    int s0;
    @(negedge clk);
    chk(err_a == 1'b0, "R8", "A wide div4 legal", err_a, 0);
    chk(err_b == 1'b0, "R8", "B late div3 legal", err_b, 0);
    wide_a = 1'b0; div_a = 6'd2;
    @(negedge clk);
    chk(err_a == 1'b1, "R8", "A late div2 too long", err_a, 1);
    s0 = mon_a.strobes;
    en_a = 1'b1;
    repeat (3 * AC) @(negedge clk);
    chk(mon_a.strobes == s0, "R8", "no frame while error", mon_a.strobes - s0, 0);
    en_a = 1'b0;
    wide_a = 1'b1; div_a = 6'd5;
    @(negedge clk);
    chk(err_a == 1'b1, "R8", "A wide div5 boundary", err_a, 1);
    div_a = 6'd1;
    @(negedge clk);
    chk(err_a == 1'b1, "R8", "div below 2", err_a, 1);
    div_a = 6'd4;
    div_b = 6'd8;
    @(negedge clk);
    chk(err_b == 1'b1, "R8", "B late div8 boundary", err_b, 1);
    div_b = 6'd7;
    @(negedge clk);
    chk(err_b == 1'b0, "R8", "B late div7 fits", err_b, 0);
    div_b = 6'd3;
    @(negedge clk);
  endtask

  task automatic t_wide();
    int s0, f0, q0, p0, pb0, w0, base;
    @(negedge clk);
    s0 = mon_a.strobes; f0 = mon_a.cs_falls; q0 = mon_a.quiet_viol;
    p0 = mon_a.period_bad; pb0 = mon_a.pulse_bad; w0 = na; base = na_model;
    en_a = 1'b1;
    while (mon_a.strobes - s0 < 6) @(negedge clk);
    en_a = 1'b0;
    repeat (2 * AC) @(negedge clk);
    chk(mon_a.strobes - s0 == 6, "R2", "wide strobes", mon_a.strobes - s0, 6);
    chk(mon_a.period_bad == p0, "R2", "wide strobe spacing", mon_a.period_bad - p0, 0);
    chk(mon_a.cs_falls - f0 == 5, "R3", "wide reads skip first frame", mon_a.cs_falls - f0, 5);
    chk(mon_a.last_rises == AW, "R3", "wide sclk rises", mon_a.last_rises, AW);
    chk(mon_a.cs_off == 0, "R4", "wide select offset", mon_a.cs_off, 0);
    chk(mon_a.pulse_bad == pb0, "R5", "wide pulse shape", mon_a.pulse_bad - pb0, 0);
    chk(mon_a.quiet_viol == q0, "R6", "wide quiet window", mon_a.quiet_viol - q0, 0);
    chk(na - w0 == 5, "R7", "wide word count", na - w0, 5);
    for (int i = 0; i < 5; i++)
      chk(wa[w0 + i] == expw(base + i, AW), "R7", "wide word", wa[w0 + i], expw(base + i, AW));
    repeat (AC) @(negedge clk);
    chk(mon_a.strobes - s0 == 6, "R2", "stopped after enable low", mon_a.strobes - s0, 6);
  endtask

  task automatic t_trad();
    int s0, f0, q0, p0, pb0, w0, base;
    @(negedge clk);
    s0 = mon_b.strobes; f0 = mon_b.cs_falls; q0 = mon_b.quiet_viol;
    p0 = mon_b.period_bad; pb0 = mon_b.pulse_bad; w0 = nb; base = nb_model;
    en_b = 1'b1;
    while (mon_b.strobes - s0 < 4) @(negedge clk);
    en_b = 1'b0;
    repeat (2 * BC) @(negedge clk);
    chk(mon_b.strobes - s0 == 4, "R2", "late strobes", mon_b.strobes - s0, 4);
    chk(mon_b.period_bad == p0, "R2", "late strobe spacing", mon_b.period_bad - p0, 0);
    chk(mon_b.cs_falls - f0 == 3, "R3", "late reads skip first frame", mon_b.cs_falls - f0, 3);
    chk(mon_b.last_rises == BW, "R3", "late sclk rises", mon_b.last_rises, BW);
    chk(mon_b.cs_off == BV, "R4", "late select offset", mon_b.cs_off, BV);
    chk(mon_b.pulse_bad == pb0, "R5", "late pulse shape", mon_b.pulse_bad - pb0, 0);
    chk(mon_b.quiet_viol == q0, "R6", "late quiet window", mon_b.quiet_viol - q0, 0);
    chk(nb - w0 == 3, "R7", "late word count", nb - w0, 3);
    for (int i = 0; i < 3; i++)
      chk(wb[w0 + i] == expw(base + i, BW), "R7", "late word", wb[w0 + i], expw(base + i, BW));
  endtask

  task automatic t_backpressure();
    int s0, w0, base;
    @(negedge clk);
    ra = 1'b0;
    s0 = mon_a.strobes; w0 = na; base = na_model;
    en_a = 1'b1;
    while (mon_a.strobes - s0 < 4) @(negedge clk);
    en_a = 1'b0;
    repeat (2 * AC) @(negedge clk);
    chk(va == 1'b1, "R9", "valid held", va, 1);
    chk(32'(da) == expw(base + 2, AW), "R9", "latest word kept", da, expw(base + 2, AW));
    chk(na == w0, "R9", "nothing accepted", na - w0, 0);
    ra = 1'b1;
    @(negedge clk);
    chk(va == 1'b0, "R9", "valid drops after accept", va, 0);
    chk(na - w0 == 1, "R9", "one word accepted", na - w0, 1);
    chk(wa[w0] == expw(base + 2, AW), "R9", "accepted word", wa[w0], expw(base + 2, AW));
  endtask

  initial begin
    rst_n = 1'b0;
    en_a = 1'b0; wide_a = 1'b1; div_a = 6'd4; ra = 1'b1;
    en_b = 1'b0; wide_b = 1'b0; div_b = 6'd3; rb = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_wide();
    t_trad();
    t_backpressure();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule